// File: doc/BRIEF.md
# Windowed Conversion Interrupt with Persistence Filter

This block watches the stream of conversion results from a light-measurement converter and raises an interrupt when the readings leave a programmable window. Each result arrives with a one-cycle strobe. The block compares it against a low bound and a high bound. It counts how many results in a row fall outside the window. The interrupt fires only when that run reaches a length chosen by a 2-bit persistence code, so a single noisy reading does not cause a false alarm.

Once it fires, a sticky flag goes high and an active-low interrupt output (meant to drive an open-drain pad) goes low. Both stay that way until a one-cycle clear pulse arrives. That pulse is produced when software reads the command register. One pair of bounds serves every colour channel, so software reloads the bounds between channels when each channel needs its own window. Any change to either bound or to the persistence code restarts the run. The registers that store the bounds and the bus interface are outside this block.

Top module: `win_irq_persist`

## Requirements
- R1: A result is outside the window when it is strictly less than `thr_lo` or strictly greater than `thr_hi`. A result equal to either bound is inside the window.
- R2: `persist_code` selects the run length that fires the interrupt: 2'b00 needs 1 result, 2'b01 needs 4, 2'b10 needs 8 and 2'b11 needs 16 consecutive out-of-window results. The flag rises on the clock edge that accepts the last result of the run.
- R3: An in-window result sets the run length back to zero.
- R4: Once set, `int_flag` stays 1 and `int_n` stays 0 until a clear pulse arrives, whatever results arrive in the meantime. `int_n` is always the inverse of `int_flag`.
- R5: A `flag_clr` pulse clears the flag on the next edge, so `int_flag` becomes 0 and `int_n` becomes 1. The same pulse also restarts the run from zero.
- R6: If a clear pulse and a result that completes a run arrive in the same cycle, the flag stays set.
- R7: A change of `thr_lo`, `thr_hi` or `persist_code` restarts the run from zero.
- R8: After reset `int_flag` is 0 and `int_n` is 1. With bounds 0x0000 and 0xFFFF, no 16-bit result ever fires.
- R9: Cycles without `res_valid` do not change the run length. Consecutive means consecutive results, not consecutive clock cycles.
- R10: While the flag is set, the run length saturates at its target. After a clear, a full new run is needed to fire again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| res_valid | input | 1 | One-cycle strobe: a new conversion result is present |
| res_data | input | DW | Conversion result |
| thr_lo | input | DW | Low bound of the window |
| thr_hi | input | DW | High bound of the window |
| persist_code | input | 2 | Run-length select (1, 4, 8, 16) |
| flag_clr | input | 1 | One-cycle clear, produced by a read of the command register |
| int_flag | output | 1 | Sticky interrupt flag, active high |
| int_n | output | 1 | Interrupt request, active low |

## Verification
The assertions assume that `flag_clr` and `res_valid` are single-cycle pulses taken in the clock domain, and that the bounds and the persistence code are quasi-static. Those inputs may change on any cycle, but each change counts as a restart of the run. The bench drives every input at the falling edge and raises each strobe for exactly one cycle. It changes the configuration only through a task that leaves an idle cycle afterwards. The one exception is the same-cycle case: the R6 scenario deliberately raises a clear and a completing result in the same cycle.

// File: rtl/wip_pkg.sv
package wip_pkg;

    localparam int unsigned PERSIST_MAX = 16;
    localparam int unsigned CNT_W       = $clog2(PERSIST_MAX + 1);

    typedef enum logic [1:0] {
        PS_RUN1  = 2'b00,
        PS_RUN4  = 2'b01,
        PS_RUN8  = 2'b10,
        PS_RUN16 = 2'b11
    } persist_e;

    typedef struct packed {
        logic valid;
        logic below;
        logic above;
    } cmp_res_t;

    function automatic logic [CNT_W-1:0] run_target(input logic [1:0] code);
        logic [CNT_W-1:0] t;
        case (persist_e'(code))
            PS_RUN1:  t = CNT_W'(1);
            PS_RUN4:  t = CNT_W'(4);
            PS_RUN8:  t = CNT_W'(8);
            default:  t = CNT_W'(16);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/wip_window_cmp.sv
module wip_window_cmp
    import wip_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          valid,
    input  logic [DW-1:0] data,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    output cmp_res_t      res
);
    always_comb begin
        res.valid = valid;
        res.below = (data < lo);
        res.above = (data > hi);
    end
endmodule

// File: rtl/wip_cfg_watch.sv
module wip_cfg_watch #(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [DW-1:0] lo,
    input  logic [DW-1:0] hi,
    input  logic [1:0]    code,
    output logic          changed
);
    logic [DW-1:0] lo_q, hi_q;
    logic [1:0]    code_q;

    // Shadow copies start at the power-up bound values.
    always_ff @(posedge clk) begin
        if (rst) begin
            lo_q   <= '0;
            hi_q   <= '1;
            code_q <= 2'b00;
        end else begin
            lo_q   <= lo;
            hi_q   <= hi;
            code_q <= code;
        end
    end

    assign changed = (lo != lo_q) || (hi != hi_q) || (code != code_q);
endmodule

// File: rtl/wip_run_ctr.sv
module wip_run_ctr
    import wip_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  cmp_res_t         res,
    input  logic             restart,
    input  logic [CNT_W-1:0] target,
    output logic             trig,
    output logic [CNT_W-1:0] cnt
);
    logic [CNT_W-1:0] base;
    logic [CNT_W:0]   inc;
    logic             outside;
    logic [CNT_W-1:0] cnt_d;

    always_comb begin
        outside = res.below | res.above;
        base    = restart ? '0 : cnt;
        inc     = {1'b0, base} + 1'b1;
        trig    = res.valid && outside && (inc >= {1'b0, target});
        cnt_d   = base;
        if (res.valid) begin
            if (!outside)
                cnt_d = '0;
            else if (inc >= {1'b0, target})
                cnt_d = target;
            else
                cnt_d = inc[CNT_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_d;
    end

    p_inwin_zero_r3: assert property (@(posedge clk) disable iff (rst)
        res.valid && !res.below && !res.above |=> cnt == '0);

    p_restart_zero_r7: assert property (@(posedge clk) disable iff (rst)
        restart && !res.valid |=> cnt == '0);

    p_cnt_cap_r10: assert property (@(posedge clk) disable iff (rst)
        !restart |-> cnt <= target);
endmodule

// File: rtl/wip_flag_latch.sv
module wip_flag_latch (
    input  logic clk,
    input  logic rst,
    input  logic trig,
    input  logic clr,
    output logic flag
);
    always_ff @(posedge clk) begin
        if (rst) flag <= 1'b0;
        else     flag <= trig | (flag & ~clr);
    end

    p_flag_hold_r4: assert property (@(posedge clk) disable iff (rst)
        flag && !clr |=> flag);

    p_clr_drop_r5: assert property (@(posedge clk) disable iff (rst)
        clr && !trig |=> !flag);

    p_trig_wins_r6: assert property (@(posedge clk) disable iff (rst)
        trig |=> flag);
endmodule

// File: rtl/win_irq_persist.sv
module win_irq_persist
    import wip_pkg::*;
#(
    parameter int unsigned DW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          res_valid,
    input  logic [DW-1:0] res_data,
    input  logic [DW-1:0] thr_lo,
    input  logic [DW-1:0] thr_hi,
    input  logic [1:0]    persist_code,
    input  logic          flag_clr,
    output logic          int_flag,
    output logic          int_n
);
    cmp_res_t         cmp;
    logic             cfg_chg;
    logic             trig;
    logic [CNT_W-1:0] run_cnt;

    wip_window_cmp #(.DW(DW)) u_cmp (
        .valid (res_valid),
        .data  (res_data),
        .lo    (thr_lo),
        .hi    (thr_hi),
        .res   (cmp)
    );

    wip_cfg_watch #(.DW(DW)) u_cfg (
        .clk     (clk),
        .rst     (rst),
        .lo      (thr_lo),
        .hi      (thr_hi),
        .code    (persist_code),
        .changed (cfg_chg)
    );

    wip_run_ctr u_ctr (
        .clk     (clk),
        .rst     (rst),
        .res     (cmp),
        .restart (flag_clr | cfg_chg),
        .target  (run_target(persist_code)),
        .trig    (trig),
        .cnt     (run_cnt)
    );

    wip_flag_latch u_flag (
        .clk  (clk),
        .rst  (rst),
        .trig (trig),
        .clr  (flag_clr),
        .flag (int_flag)
    );

    assign int_n = ~int_flag;

    p_rise_on_result_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(int_flag) |-> $past(res_valid));
endmodule

// File: tb/sim_win_irq_persist.sv
module sim_win_irq_persist;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst;
    logic          res_valid;
    logic [DW-1:0] res_data;
    logic [DW-1:0] thr_lo;
    logic [DW-1:0] thr_hi;
    logic [1:0]    persist_code;
    logic          flag_clr;
    logic          int_flag;
    logic          int_n;

    int checks = 0;
    int fails  = 0;

    always #10 clk = ~clk;

    win_irq_persist #(.DW(DW)) u0 (
        .clk(clk), .rst(rst), .res_valid(res_valid), .res_data(res_data),
        .thr_lo(thr_lo), .thr_hi(thr_hi), .persist_code(persist_code),
        .flag_clr(flag_clr), .int_flag(int_flag), .int_n(int_n)
    );

    task automatic chk_out(input string tag, input logic exp_flag);
        checks++;
        if (int_flag !== exp_flag || int_n !== !exp_flag) begin
            fails++;
            $display("FAIL %s actual flag=%b n=%b expected flag=%b n=%b",
                     tag, int_flag, int_n, exp_flag, !exp_flag);
        end
    endtask

    task automatic conv(input logic [DW-1:0] v);
        @(negedge clk);
        res_data  = v;
        res_valid = 1'b1;
        @(negedge clk);
        res_valid = 1'b0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_clr();
        @(negedge clk);
        flag_clr = 1'b1;
        @(negedge clk);
        flag_clr = 1'b0;
    endtask

    task automatic set_cfg(input logic [DW-1:0] lo, input logic [DW-1:0] hi,
                           input logic [1:0] ps);
        @(negedge clk);
        thr_lo = lo;
        thr_hi = hi;
        persist_code = ps;
        @(negedge clk);
    endtask

    task automatic run_out(input int n);
        for (int i = 0; i < n; i++) conv(16'd500);
    endtask

    task automatic t_reset_r8();
        chk_out("R8 reset state", 1'b0);
        conv(16'h0000);
        conv(16'hFFFF);
        conv(16'h1234);
        chk_out("R8 default bounds never fire", 1'b0);
    endtask

    task automatic t_window_r1();
        set_cfg(16'd100, 16'd200, 2'b00);
        conv(16'd100);
        conv(16'd200);
        chk_out("R1 equal to bounds is inside", 1'b0);
        conv(16'd99);
        chk_out("R1 below low fires", 1'b1);
        pulse_clr();
        conv(16'd201);
        chk_out("R1 above high fires", 1'b1);
        pulse_clr();
    endtask

    task automatic t_persist_r2();
        int lens[4] = '{1, 4, 8, 16};
        for (int k = 0; k < 4; k++) begin
            set_cfg(16'd100, 16'd200, 2'(k));
            pulse_clr();
            run_out(lens[k] - 1);
            chk_out($sformatf("R2 code %0d one short", k), 1'b0);
            run_out(1);
            chk_out($sformatf("R2 code %0d full run", k), 1'b1);
            pulse_clr();
        end
    endtask

    task automatic t_inwin_r3();
        set_cfg(16'd100, 16'd200, 2'b01);
        run_out(3);
        conv(16'd150);
        run_out(3);
        chk_out("R3 in-window result resets run", 1'b0);
        run_out(1);
        chk_out("R3 run completes after reset", 1'b1);
        pulse_clr();
    endtask

    task automatic t_sticky_r4();
        set_cfg(16'd100, 16'd200, 2'b00);
        conv(16'd10);
        conv(16'd150);
        idle(5);
        conv(16'd160);
        chk_out("R4 flag holds through in-window results", 1'b1);
        pulse_clr();
        chk_out("R4 flag clears only on clear", 1'b0);
    endtask

    task automatic t_clear_r5();
        set_cfg(16'd100, 16'd200, 2'b01);
        run_out(2);
        pulse_clr();
        run_out(2);
        chk_out("R5 clear restarts run", 1'b0);
        run_out(2);
        chk_out("R5 new run fires", 1'b1);
        pulse_clr();
        chk_out("R5 clear drops flag", 1'b0);
    endtask

    task automatic t_same_cycle_r6();
        set_cfg(16'd100, 16'd200, 2'b00);
        conv(16'd5);
        @(negedge clk);
        flag_clr  = 1'b1;
        res_data  = 16'd5;
        res_valid = 1'b1;
        @(negedge clk);
        flag_clr  = 1'b0;
        res_valid = 1'b0;
        chk_out("R6 trigger beats clear", 1'b1);
        pulse_clr();
    endtask

    task automatic t_cfg_r7();
        set_cfg(16'd100, 16'd200, 2'b01);
        run_out(3);
        set_cfg(16'd100, 16'd201, 2'b01);
        run_out(1);
        chk_out("R7 bound change restarts run", 1'b0);
        run_out(2);
        set_cfg(16'd100, 16'd201, 2'b10);
        set_cfg(16'd100, 16'd201, 2'b01);
        run_out(3);
        chk_out("R7 code change restarts run", 1'b0);
        run_out(1);
        chk_out("R7 full run after change", 1'b1);
        pulse_clr();
    endtask

    task automatic t_gap_r9();
        set_cfg(16'd100, 16'd200, 2'b01);
        for (int i = 0; i < 4; i++) begin
            conv(16'd400);
            idle(3);
        end
        chk_out("R9 idle cycles keep the run", 1'b1);
        pulse_clr();
    endtask

    task automatic t_sat_r10();
        set_cfg(16'd100, 16'd200, 2'b01);
        run_out(4);
        run_out(6);
        chk_out("R10 flag set during long run", 1'b1);
        pulse_clr();
        run_out(3);
        chk_out("R10 full run needed after clear", 1'b0);
        run_out(1);
        chk_out("R10 refires after full run", 1'b1);
        pulse_clr();
    endtask

    initial begin
        rst = 1'b1;
        res_valid = 1'b0;
        res_data = '0;
        thr_lo = 16'h0000;
        thr_hi = 16'hFFFF;
        persist_code = 2'b00;
        flag_clr = 1'b0;
        idle(3);
        rst = 1'b0;
        @(negedge clk);
        t_reset_r8();
        t_window_r1();
        t_persist_r2();
        t_inwin_r3();
        t_sticky_r4();
        t_clear_r5();
        t_same_cycle_r6();
        t_cfg_r7();
        t_gap_r9();
        t_sat_r10();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        #(20 * 150000);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule